// File: doc/BRIEF.md
# Frame-Synchronous Byte Scrambler

This block scrambles or descrambles a byte stream with the self-synchronising-free SONET sequence generated by 1 + x^6 + x^7. It is frame-aligned. A frame-start marker that travels with the data tells the block where each frame begins. The first 36 bytes of every frame are the framing and trace overhead, and they pass through untouched. The sequence generator is reloaded on the byte that follows them and keeps running until the next frame start.

Each byte is XORed with one sequence byte, so the same block is a descrambler on the receive side, where it sits between deserialisation and switching. It is a scrambler on the transmit side, where it sits between switching and serialisation. Processing is on when either the hardware strap pin or the soft enable bit is high. When it is off, bytes pass unchanged through the same single register stage, so the latency does not depend on the mode.

The data path is a valid/ready stream on both sides. A byte moves on a rising edge where valid and ready are both high. The input is ready whenever the output register is empty or is being drained in the same cycle. A stalled output holds its byte and its frame marker unchanged, and that stall reaches the input within the same cycle.

Top module: `fss_scrambler`

## Requirements
- R1: The sequence comes from a 7-bit generator for 1 + x^6 + x^7, loaded with all ones at the restart byte. It yields eight bits per byte, and the first bit goes to the byte's MSB. On an all-zero frame, bytes 36, 37, 38 and 39 come out as FE, 04, 18 and 51 (hex).
- R2: A byte accepted with in_sof high is byte 0 of a frame. Bytes 0 to 35 of every frame leave the block equal to the bytes that came in.
- R3: The generator restarts at byte 36 of every frame, whatever the length of the previous frame. A frame start that arrives early re-aligns the count at once.
- R4: Processing is on for a byte when scr_pin or scr_soft is high in the cycle that byte is accepted.
- R5: With both enables low, bytes pass unchanged. The generator still advances on every byte from 36 onwards, so enabling processing in mid-frame applies the sequence byte that belongs to that position.
- R6: A byte accepted on one edge is presented at the output from the next edge. out_sof carries the frame-start marker of that same byte.
- R7: While out_valid is high and out_ready is low, out_valid, out_data and out_sof hold steady. in_ready is high exactly when the output register is empty or out_ready is high.
- R8: After reset, bytes pass unchanged until the first frame start is seen.
- R9: Reset empties the output stage, so out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is byte 0 of a frame |
| scr_pin | input | 1 | Hardware scramble strap |
| scr_soft | input | 1 | Soft scramble enable bit |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Processed byte |
| out_sof | output | 1 | Frame-start marker of the output byte |

## Verification
A wrong byte position shows up within one frame. Either an overhead byte comes out altered or the first payload byte differs from FE on zero data. A wrong generator state or feedback tap shows in the very next payload byte, because every later sequence byte depends on it. A generator that stops advancing while processing is off is only visible once processing turns back on in mid-frame, so the stimulus toggles the enables inside a frame. It also applies back-pressure so that stalls land on overhead bytes, on the restart byte and on payload bytes.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              sof;
    logic [BYTE_W-1:0] data;
  } fss_beat_t;
endpackage

// File: rtl/fss_frame_pos.sv
module fss_frame_pos #(
  parameter int OH_BYTES = 36,
  localparam int POS_W = $clog2(OH_BYTES + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sof,
  output logic in_payload,
  output logic at_restart
);
  localparam logic [POS_W-1:0] OH_POS  = POS_W'(OH_BYTES);
  localparam logic [POS_W-1:0] PAST_OH = POS_W'(OH_BYTES + 1);

  logic [POS_W-1:0] pos_q;
  logic             locked_q;
  logic [POS_W-1:0] idx;
  logic             locked;

  // byte index of the byte currently offered
  assign idx        = sof ? '0 : pos_q;
  assign locked     = locked_q | sof;
  assign in_payload = locked && (idx >= OH_POS);
  assign at_restart = locked && (idx == OH_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= PAST_OH;
      locked_q <= 1'b0;
    end else if (take) begin
      pos_q    <= (idx >= OH_POS) ? PAST_OH : idx + 1'b1;
      locked_q <= locked;
    end
  end
endmodule

// File: rtl/fss_keystream.sv
module fss_keystream #(
  parameter int GEN_W  = 7,
  parameter int FB_TAP = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  output logic [BYTE_W-1:0] key
);
  localparam logic [GEN_W-1:0] SEED = '1;

  logic [GEN_W-1:0] state_q;
  logic [GEN_W-1:0] chain [0:BYTE_W];

  assign chain[0] = restart ? SEED : state_q;

  // unrolled bit-serial generator: first bit lands in the MSB
  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign key[BYTE_W-1-b] = chain[b][GEN_W-1];
    assign chain[b+1] = {chain[b][GEN_W-2:0],
                         chain[b][GEN_W-1] ^ chain[b][FB_TAP]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= SEED;
    else if (step) state_q <= chain[BYTE_W];
  end
endmodule

// File: rtl/fss_out_stage.sv
module fss_out_stage
  import fss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      up_valid,
  output logic      up_ready,
  input  fss_beat_t up_beat,
  output logic      dn_valid,
  input  logic      dn_ready,
  output fss_beat_t dn_beat
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_beat  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_beat <= up_beat;
    end
  end
endmodule

// File: rtl/fss_scrambler.sv
module fss_scrambler
  import fss_pkg::*;
#(
  parameter int OH_BYTES = 36,
  parameter int GEN_W    = 7,
  parameter int FB_TAP   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              scr_pin,
  input  logic              scr_soft,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof
);
  logic              take;
  logic              in_payload;
  logic              at_restart;
  logic [BYTE_W-1:0] key;
  logic [BYTE_W-1:0] mask;
  fss_beat_t         up_beat;
  fss_beat_t         dn_beat;

  assign take = in_valid && in_ready;

  fss_frame_pos #(.OH_BYTES(OH_BYTES)) u_pos (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof),
    .in_payload(in_payload), .at_restart(at_restart)
  );

  fss_keystream #(.GEN_W(GEN_W), .FB_TAP(FB_TAP), .BYTE_W(BYTE_W)) u_key (
    .clk(clk), .rst_n(rst_n), .step(take && in_payload),
    .restart(at_restart), .key(key)
  );

  assign mask         = ((scr_pin || scr_soft) && in_payload) ? key : '0;
  assign up_beat.sof  = in_sof;
  assign up_beat.data = in_data ^ mask;

  fss_out_stage u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_beat(up_beat),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_beat(dn_beat)
  );

  assign out_data = dn_beat.data;
  assign out_sof  = dn_beat.sof;
endmodule

// File: rtl/fss_scrambler_chk.sv
module fss_scrambler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic       scr_pin,
  input logic       scr_soft,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));

  // R7
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R6
  accept_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_sof == $past(in_sof));

  // R6
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !in_valid |=> !out_valid);

  // R2
  sof_byte_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sof |=> out_data == $past(in_data));

  // R5
  off_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !scr_pin && !scr_soft |=> out_data == $past(in_data));
endmodule

bind fss_scrambler fss_scrambler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sof(in_sof), .scr_pin(scr_pin), .scr_soft(scr_soft),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof)
);

// File: tb/tb_fss_scrambler.sv
module tb_fss_scrambler;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [7:0] in_data = 0;
  logic       in_sof = 0;
  logic       scr_pin = 0;
  logic       scr_soft = 0;
  logic       out_valid;
  logic       out_ready = 1;
  logic [7:0] out_data;
  logic       out_sof;

  always #10 clk = ~clk;

  fss_scrambler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .scr_pin(scr_pin), .scr_soft(scr_soft),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof)
  );

  typedef struct {
    logic [7:0] data;
    logic       sof;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   stall_mode = 0;
  int   cyc = 0;

  // reference model state
  int       m_pos = 37;
  bit       m_lock = 0;
  bit [6:0] m_gen = 7'h7f;

  function automatic logic [7:0] model(input logic [7:0] d, input logic s, input logic en);
    int idx;
    logic [7:0] k;
    idx = s ? 0 : m_pos;
    if (s) m_lock = 1;
    k = 0;
    if (m_lock && idx >= 36) begin
      if (idx == 36) m_gen = 7'h7f;
      for (int b = 0; b < 8; b++) begin
        k = {k[6:0], m_gen[6]};
        m_gen = {m_gen[5:0], m_gen[6] ^ m_gen[5]};
      end
    end
    m_pos = (idx >= 36) ? 37 : idx + 1;
    return (en && m_lock && idx >= 36) ? (d ^ k) : d;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int ex);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, ex);
    end
  endtask

  task automatic push_byte(input logic [7:0] d, input logic s, input logic p, input logic f,
                           input logic [7:0] e, input string tag);
    in_valid = 1; in_data = d; in_sof = s; scr_pin = p; scr_soft = f;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    exp_q.push_back('{e, s, tag});
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic s, input logic p, input logic f,
                      input string tag);
    logic [7:0] e;
    e = model(d, s, p | f);
    push_byte(d, s, p, f, e, tag);
  endtask

  task automatic send_frame(input int len, input logic p, input logic f,
                            input int seed, input string tag_oh, input string tag_pl);
    for (int i = 0; i < len; i++)
      send(8'((i * 29 + seed) & 8'hff), i == 0, p, f, (i < 36) ? tag_oh : tag_pl);
  endtask

  // downstream ready pattern
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // scoreboard monitor
  bit         held = 0;
  logic [7:0] held_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held && out_valid) check(out_data == held_data, "R7", out_data, held_data);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R6", out_data, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_data == e.data, e.tag, out_data, e.data);
          check(out_sof == e.sof, "R6", out_sof, e.sof);
        end
      end
      held = out_valid && !out_ready;
      held_data = out_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] e;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R9", out_valid, 0);
    check(in_ready == 1, "R9", in_ready, 1);
    @(posedge clk); #1;

    // R8: before any frame start bytes pass unchanged
    for (int i = 0; i < 6; i++) send(8'(8'hA0 + i), 0, 1, 1, "R8");

    // R1: zero payload gives the raw sequence
    for (int i = 0; i < 36; i++) send(8'h00, i == 0, 1, 0, "R2");
    e = model(8'h00, 0, 1); push_byte(8'h00, 0, 1, 0, 8'hFE, "R1");
    e = model(8'h00, 0, 1); push_byte(8'h00, 0, 1, 0, 8'h04, "R1");
    e = model(8'h00, 0, 1); push_byte(8'h00, 0, 1, 0, 8'h18, "R1");
    e = model(8'h00, 0, 1); push_byte(8'h00, 0, 1, 0, 8'h51, "R1");
    for (int i = 0; i < 20; i++) send(8'h00, 0, 1, 0, "R1");

    // R3: frames of different lengths, restart each time
    send_frame(90, 1, 0, 5, "R2", "R3");
    send_frame(40, 0, 1, 11, "R2", "R3");
    // R3: early frame start inside overhead
    send_frame(20, 1, 1, 3, "R2", "R3");
    send_frame(60, 1, 1, 7, "R2", "R3");

    // R7: back-pressure during a full frame
    stall_mode = 1;
    send_frame(70, 1, 0, 17, "R2", "R7");
    stall_mode = 0;

    // R5: processing off
    send_frame(60, 0, 0, 23, "R2", "R5");

    // R4 and R5: enables toggled inside a frame
    for (int i = 0; i < 80; i++) begin
      logic p, f;
      p = (i % 7) < 2;
      f = (i % 5) == 3;
      send(8'((i * 13 + 1) & 8'hff), i == 0, p, f, (i < 36) ? "R2" : ((p | f) ? "R4" : "R5"));
    end

    // R4: soft bit alone
    send_frame(50, 0, 1, 41, "R2", "R4");

    repeat (10) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    check(out_valid == 0, "R6", out_valid, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule